// File: doc/BRIEF.md
# Dual-Domain Software Reset Pulse Generator

This block turns one host register write into a pair of fixed-width reset pulses for a datapath that runs on two clocks. The host bus runs on the processing clock. The write is decoded there and starts a back-end pulse right away. A toggle request carries the write into the input sample clock domain, where it starts a front-end pulse of the same length, counted on that clock. Because each pulse is counted by its own domain's clock, every pipeline stage on either side sees a whole reset window, and no stage enable stays set when the pulse ends.

Besides the two pulses, the block drives strobes for two oscillator units. The carrier oscillator's phase-offset load strobe rides with the front-end pulse. It carries a phase offset that was taken from the host side when the write was accepted. A timing-oscillator feedback clear rides with the back-end pulse, but only while a configuration bit enables it. A busy status stays high until both pulses have ended and the input domain has acknowledged the request. A write that arrives while a reset is still running restarts the pulses; it is never dropped.

Top module: `softrst_pulse_gen`

## Requirements
- R1: A processing-clock cycle with `wr_en` high and `wr_addr` equal to `RST_ADDR` starts a reset. A write to any other address starts no pulse, and `be_rst` only rises in the cycle after a matching write.
- R2: `be_rst` rises on the first processing-clock edge after the write and stays high for exactly `PULSE_LEN` (default 10) processing-clock cycles.
- R3: Each isolated write makes exactly one `fe_rst` pulse, exactly `PULSE_LEN` input-clock cycles wide.
- R4: `tnco_clr` is high in a cycle only if `be_rst` is high and `tnco_en` was 1 on the previous edge. With `tnco_en` at 0, `tnco_clr` stays low through the whole reset. With it at 1, `tnco_clr` lasts as long as `be_rst`.
- R5: `cnco_load` is high in exactly the input-clock cycles in which `fe_rst` is high. `cnco_phase` shows the `phase_in` value that was sampled on the accepted write.
- R6: A matching write while a reset is active restarts the count. `be_rst` then stays high until `PULSE_LEN` cycles after the latest write. `fe_rst` forms one continuous pulse at least `PULSE_LEN` cycles long, and `cnco_phase` ends on the latest write's `phase_in`.
- R7: `busy` is high from the cycle after an accepted write until both pulses have ended and the acknowledge has returned. Whenever `busy` is low, `be_rst`, `tnco_clr` and `fe_rst` are low.
- R8: While either reset input is low, and right after reset is released, every output is 0 (`cnco_phase` is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| proc_clk | input | 1 | Processing clock (host and back-end domain) |
| proc_rst_n | input | 1 | Asynchronous active-low reset, processing domain |
| in_clk | input | 1 | Input sample clock (front-end domain) |
| in_rst_n | input | 1 | Asynchronous active-low reset, input domain |
| wr_en | input | 1 | Host write strobe, processing domain |
| wr_addr | input | ADDR_W | Host write address |
| phase_in | input | PH_W | Carrier phase offset to be loaded on reset |
| tnco_en | input | 1 | Configuration: 1 lets reset clear timing-oscillator feedback |
| be_rst | output | 1 | Back-end reset pulse, processing domain |
| tnco_clr | output | 1 | Timing-oscillator feedback clear, processing domain |
| busy | output | 1 | Reset sequence in progress |
| fe_rst | output | 1 | Front-end reset pulse, input domain |
| cnco_load | output | 1 | Carrier-oscillator phase-offset load strobe, input domain |
| cnco_phase | output | PH_W | Phase offset for the carrier oscillator, input domain |

## Verification
On every processing-clock edge, the assertions check when the back-end pulse may start and how long it lasts. They also check that the timing-oscillator clear stays inside that pulse and obeys its enable, and that nothing is driven while the block reports idle. On the input clock they check that the load strobe stays locked to the front-end pulse. The front-end pulse width, the phase value carried across the clock boundary, the ordering of `busy` against the far-domain pulse, and the merging of a restart write into one continuous pulse all span both clocks. Only the bench scenarios show those.

// File: rtl/srg_pkg.sv
package srg_pkg;

    localparam int SRG_CNT_W = 16;

    typedef logic [SRG_CNT_W-1:0] srg_cnt_t;

    // Next value of a pulse-length down counter: reload wins, else count to zero.
    function automatic srg_cnt_t srg_cnt_step(input logic load, input srg_cnt_t cur,
                                              input srg_cnt_t len);
        if (load) begin
            return len;
        end else if (cur != '0) begin
            return cur - srg_cnt_t'(1);
        end
        return cur;
    endfunction

endpackage

// File: rtl/srg_sync.sv
module srg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int NSTG = (STAGES < 2) ? 2 : STAGES;

    logic [NSTG-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[NSTG-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[NSTG-1];
endmodule

// File: rtl/srg_proc_side.sv
module srg_proc_side
    import srg_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              PH_W      = 10,
    parameter int              PULSE_LEN = 10,
    parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PH_W-1:0] phase_in,
    input  logic            tnco_en,
    input  logic            ack_s,
    input  logic            fe_act_s,
    output logic            req_tgl,
    output logic [PH_W-1:0] hold_phase,
    output logic            be_rst,
    output logic            tnco_clr,
    output logic            busy
);
    localparam srg_cnt_t LEN = srg_cnt_t'(PULSE_LEN);

    typedef struct packed {
        logic            req;
        logic            pend;
        srg_cnt_t        cnt;
        logic            be;
        logic            tnco;
        logic [PH_W-1:0] next_ph;
        logic [PH_W-1:0] hold_ph;
    } proc_st_t;

    proc_st_t st_d, st_q;
    logic     hit, outstanding;

    always_comb begin
        hit         = wr_en && (wr_addr == RST_ADDR);
        outstanding = (st_q.req != ack_s);
        st_d        = st_q;

        st_d.cnt = srg_cnt_step(hit, st_q.cnt, LEN);
        st_d.be  = (st_d.cnt != '0);

        if (hit) begin
            if (outstanding) begin
                // previous toggle not yet seen: park the request
                st_d.pend    = 1'b1;
                st_d.next_ph = phase_in;
            end else begin
                st_d.req     = ~st_q.req;
                st_d.hold_ph = phase_in;
                st_d.pend    = 1'b0;
            end
        end else if (st_q.pend && !outstanding) begin
            st_d.req     = ~st_q.req;
            st_d.hold_ph = st_q.next_ph;
            st_d.pend    = 1'b0;
        end

        st_d.tnco = st_d.be & tnco_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_tgl    = st_q.req;
    assign hold_phase = st_q.hold_ph;
    assign be_rst     = st_q.be;
    assign tnco_clr   = st_q.tnco;
    assign busy       = outstanding | st_q.pend | st_q.be | fe_act_s;
endmodule

// File: rtl/srg_in_side.sv
module srg_in_side
    import srg_pkg::*;
#(
    parameter int PH_W      = 10,
    parameter int PULSE_LEN = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_s,
    input  logic [PH_W-1:0] hold_phase,
    output logic            ack_tgl,
    output logic            fe_rst,
    output logic            cnco_load,
    output logic [PH_W-1:0] cnco_phase
);
    localparam srg_cnt_t LEN = srg_cnt_t'(PULSE_LEN);

    typedef struct packed {
        logic            prev;
        logic            ack;
        srg_cnt_t        cnt;
        logic            fe;
        logic            load;
        logic [PH_W-1:0] ph;
    } in_st_t;

    in_st_t st_d, st_q;
    logic   edge_seen;

    always_comb begin
        edge_seen = req_s ^ st_q.prev;
        st_d      = st_q;
        st_d.prev = req_s;
        st_d.ack  = st_q.prev;
        st_d.cnt  = srg_cnt_step(edge_seen, st_q.cnt, LEN);
        if (edge_seen) begin
            // hold_phase has been stable since the toggle left the other domain
            st_d.ph = hold_phase;
        end
        st_d.fe   = (st_d.cnt != '0);
        st_d.load = st_d.fe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_tgl    = st_q.ack;
    assign fe_rst     = st_q.fe;
    assign cnco_load  = st_q.load;
    assign cnco_phase = st_q.ph;
endmodule

// File: rtl/softrst_pulse_gen.sv
module softrst_pulse_gen #(
    parameter int                ADDR_W      = 8,
    parameter int                PH_W        = 10,
    parameter int                PULSE_LEN   = 10,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] RST_ADDR    = 8'h5C
) (
    input  logic              proc_clk,
    input  logic              proc_rst_n,
    input  logic              in_clk,
    input  logic              in_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PH_W-1:0]   phase_in,
    input  logic              tnco_en,
    output logic              be_rst,
    output logic              tnco_clr,
    output logic              busy,
    output logic              fe_rst,
    output logic              cnco_load,
    output logic [PH_W-1:0]   cnco_phase
);
    logic            req_tgl, req_s, ack_tgl;
    logic            ack_s, fe_act_s;
    logic [PH_W-1:0] hold_phase;
    logic [1:0]      back_s;

    srg_proc_side #(
        .ADDR_W(ADDR_W), .PH_W(PH_W), .PULSE_LEN(PULSE_LEN), .RST_ADDR(RST_ADDR)
    ) u_proc (
        .clk(proc_clk), .rst_n(proc_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .phase_in(phase_in), .tnco_en(tnco_en), .ack_s(ack_s), .fe_act_s(fe_act_s),
        .req_tgl(req_tgl), .hold_phase(hold_phase), .be_rst(be_rst),
        .tnco_clr(tnco_clr), .busy(busy)
    );

    srg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(in_clk), .rst_n(in_rst_n), .d(req_tgl), .q(req_s)
    );

    srg_in_side #(.PH_W(PH_W), .PULSE_LEN(PULSE_LEN)) u_in (
        .clk(in_clk), .rst_n(in_rst_n), .req_s(req_s), .hold_phase(hold_phase),
        .ack_tgl(ack_tgl), .fe_rst(fe_rst), .cnco_load(cnco_load),
        .cnco_phase(cnco_phase)
    );

    srg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_back_sync (
        .clk(proc_clk), .rst_n(proc_rst_n), .d({ack_tgl, fe_rst}), .q(back_s)
    );

    assign ack_s    = back_s[1];
    assign fe_act_s = back_s[0];
endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
    parameter int                ADDR_W    = 8,
    parameter int                PULSE_LEN = 10,
    parameter logic [ADDR_W-1:0] RST_ADDR  = 8'h5C
) (
    input logic              proc_clk,
    input logic              proc_rst_n,
    input logic              in_clk,
    input logic              in_rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              tnco_en,
    input logic              be_rst,
    input logic              tnco_clr,
    input logic              busy,
    input logic              fe_rst,
    input logic              cnco_load
);
    localparam int CW = $clog2(PULSE_LEN + 1) + 1;
    localparam logic [CW-1:0] LIM = CW'(PULSE_LEN);

    logic          hit;
    logic [CW-1:0] since_q;

    assign hit = wr_en && (wr_addr == RST_ADDR);

    // cycles since the latest accepted write, saturating at the pulse length
    always_ff @(posedge proc_clk or negedge proc_rst_n) begin
        if (!proc_rst_n) begin
            since_q <= LIM;
        end else if (hit) begin
            since_q <= '0;
        end else if (since_q < LIM) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_BE_START: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
        hit |=> be_rst);                                              // R2
    AST_BE_WIDTH: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
        be_rst == (since_q < LIM));                                   // R2
    AST_BE_CAUSE: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
        $rose(be_rst) |-> $past(hit));                                // R1
    AST_TNCO_INSIDE: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
        tnco_clr |-> be_rst);                                         // R4
    AST_TNCO_MASKED: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
        !tnco_en |=> !tnco_clr);                                      // R4
    AST_BUSY_COVER: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
        !busy |-> (!be_rst && !tnco_clr));                            // R7
    AST_LOAD_TRACKS: assert property (@(posedge in_clk) disable iff (!in_rst_n)
        cnco_load == fe_rst);                                         // R5
endmodule

bind softrst_pulse_gen srg_checker #(
    .ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN), .RST_ADDR(RST_ADDR)
) u_srg_chk (
    .proc_clk(proc_clk), .proc_rst_n(proc_rst_n), .in_clk(in_clk), .in_rst_n(in_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .tnco_en(tnco_en), .be_rst(be_rst),
    .tnco_clr(tnco_clr), .busy(busy), .fe_rst(fe_rst), .cnco_load(cnco_load)
);

// File: tb/softrst_pulse_gen_bench.sv
`timescale 1ns/1ps
module softrst_pulse_gen_bench;
    localparam int PL = 10;

    logic       proc_clk = 1'b0, in_clk = 1'b0;
    logic       proc_rst_n = 1'b0, in_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [9:0] phase_in = '0;
    logic       tnco_en = 1'b0;
    logic       be_rst, tnco_clr, busy, fe_rst, cnco_load;
    logic [9:0] cnco_phase;

    always #2.5 proc_clk = ~proc_clk;
    always #3.5 in_clk   = ~in_clk;

    softrst_pulse_gen u_softrst_pulse_gen (
        .proc_clk(proc_clk), .proc_rst_n(proc_rst_n), .in_clk(in_clk), .in_rst_n(in_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .phase_in(phase_in), .tnco_en(tnco_en),
        .be_rst(be_rst), .tnco_clr(tnco_clr), .busy(busy), .fe_rst(fe_rst),
        .cnco_load(cnco_load), .cnco_phase(cnco_phase)
    );

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // run monitors
    int be_cur = 0, be_last = 0, be_runs = 0;
    int tn_cur = 0, tn_last = 0, tn_runs = 0;
    int fe_cur = 0, fe_last = 0, fe_runs = 0;
    int ld_cur = 0, ld_last = 0;
    int ph_seen = 0;
    bit busy_prev = 1'b0, mon_on = 1'b0;

    always @(negedge proc_clk) begin
        if (be_rst) be_cur++;
        else if (be_cur > 0) begin be_last = be_cur; be_runs++; be_cur = 0; end
        if (tnco_clr) tn_cur++;
        else if (tn_cur > 0) begin tn_last = tn_cur; tn_runs++; tn_cur = 0; end
        if (mon_on && busy_prev && !busy)
            chk(!fe_rst && !be_rst, "R7 idle-at-busy-fall", int'(fe_rst) + int'(be_rst), 0);
        busy_prev = busy;
    end

    always @(negedge in_clk) begin
        if (fe_rst) fe_cur++;
        else if (fe_cur > 0) begin fe_last = fe_cur; fe_runs++; fe_cur = 0; end
        if (cnco_load) begin ld_cur++; ph_seen = int'(cnco_phase); end
        else if (ld_cur > 0) begin ld_last = ld_cur; ld_cur = 0; end
    end

    task automatic clear_mon();
        be_last = 0; be_runs = 0; tn_last = 0; tn_runs = 0;
        fe_last = 0; fe_runs = 0; ld_last = 0; ph_seen = -1;
    endtask

    task automatic host_write(input logic [7:0] a, input logic [9:0] ph);
        @(negedge proc_clk);
        wr_en = 1'b1; wr_addr = a; phase_in = ph;
        @(negedge proc_clk);
        wr_en = 1'b0; wr_addr = 8'h00; phase_in = 10'h2AA;
    endtask

    typedef struct packed {
        logic [7:0] addr;
        logic [9:0] ph;
        logic       ten;
        logic       fire;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{addr: 8'h5C, ph: 10'h155, ten: 1'b1, fire: 1'b1},
        '{addr: 8'h5D, ph: 10'h0F0, ten: 1'b1, fire: 1'b0},
        '{addr: 8'h5C, ph: 10'h3FF, ten: 1'b0, fire: 1'b1},
        '{addr: 8'hDC, ph: 10'h011, ten: 1'b1, fire: 1'b0},
        '{addr: 8'h5C, ph: 10'h001, ten: 1'b1, fire: 1'b1},
        '{addr: 8'h1C, ph: 10'h222, ten: 1'b0, fire: 1'b0}
    };

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge proc_clk);
        // R8: outputs quiet while held in reset
        chk({be_rst, tnco_clr, busy, fe_rst, cnco_load} == 5'b0, "R8 in reset",
            int'({be_rst, tnco_clr, busy, fe_rst, cnco_load}), 0);
        proc_rst_n = 1'b1; in_rst_n = 1'b1;
        repeat (4) @(negedge proc_clk);
        chk({be_rst, tnco_clr, busy, fe_rst, cnco_load} == 5'b0 && cnco_phase == '0,
            "R8 after release", int'({be_rst, tnco_clr, busy, fe_rst, cnco_load}), 0);
        mon_on = 1'b1;

        foreach (VEC[i]) begin
            clear_mon();
            tnco_en = VEC[i].ten;
            host_write(VEC[i].addr, VEC[i].ph);
            chk(busy == VEC[i].fire, "R7 busy after write", int'(busy), int'(VEC[i].fire));
            repeat (60) @(negedge proc_clk);
            if (VEC[i].fire) begin
                chk(be_runs == 1 && be_last == PL, "R2 back-end width", be_last, PL);
                chk(fe_runs == 1 && fe_last == PL, "R3 front-end width", fe_last, PL);
                chk(tn_last == (VEC[i].ten ? PL : 0), "R4 timing clear", tn_last,
                    VEC[i].ten ? PL : 0);
                chk(ld_last == PL, "R5 load width", ld_last, PL);
                chk(ph_seen == int'(VEC[i].ph), "R5 phase value", ph_seen, int'(VEC[i].ph));
            end else begin
                chk(be_runs == 0 && fe_runs == 0, "R1 wrong address ignored",
                    be_runs + fe_runs, 0);
                chk(tn_runs == 0, "R1 no timing clear", tn_runs, 0);
            end
            chk(!busy, "R7 idle at end", int'(busy), 0);
        end

        // R6: second write six cycles after the first restarts both pulses
        clear_mon();
        tnco_en = 1'b1;
        host_write(8'h5C, 10'h0A5);
        repeat (4) @(negedge proc_clk);
        host_write(8'h5C, 10'h35A);
        repeat (60) @(negedge proc_clk);
        chk(be_runs == 1 && be_last == PL + 6, "R6 back-end restart", be_last, PL + 6);
        chk(tn_last == PL + 6, "R6 timing clear restart", tn_last, PL + 6);
        chk(fe_runs == 1 && fe_last >= PL, "R6 front-end single pulse", fe_runs, 1);
        chk(ph_seen == 10'h35A, "R6 latest phase", ph_seen, 10'h35A);

        // R6: write right after the first, before the request crosses
        clear_mon();
        host_write(8'h5C, 10'h100);
        host_write(8'h5C, 10'h2F0);
        repeat (60) @(negedge proc_clk);
        chk(be_runs == 1 && be_last == PL + 2, "R6 back-to-back width", be_last, PL + 2);
        chk(fe_runs == 1 && fe_last >= PL, "R6 back-to-back front-end", fe_runs, 1);
        chk(ph_seen == 10'h2F0, "R6 back-to-back phase", ph_seen, 10'h2F0);

        // R4: enable dropped mid-pulse stops the clear while the reset continues
        clear_mon();
        tnco_en = 1'b1;
        host_write(8'h5C, 10'h00F);
        repeat (3) @(negedge proc_clk);
        tnco_en = 1'b0;
        repeat (60) @(negedge proc_clk);
        chk(be_last == PL && tn_last < PL && tn_last > 0, "R4 enable drop", tn_last, 4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule